// File: doc/BRIEF.md
# UART Interrupt Identification and Prioritizer

This block collects every interrupt cause of a 16550-style UART operating in modem mode and turns them into one six-bit identification code plus a single active-low interrupt line. Some causes are sticky flags set by one-cycle event pulses: line error, receive timeout, XOFF seen, special character seen, modem pin released. Others are live comparisons of the FIFO fill levels against programmable thresholds. Each sticky flag has its own clearing rule, so the block tracks which cause produced a code and clears only that one.

A host reads the identification register by pulsing `iir_rd`. The code present in that cycle is captured into `iir_rdata`, and the read clears only the cause that code stands for. A wake-up path runs beside the code. It drives the interrupt line and its own status bit but never changes the code.

Top module: `uart_irq_prioritizer`

## Requirements
- R1: After reset `iir_code` and `iir_rdata` equal 6'b000001 (nothing pending), `irq_n` is 1 and `wake_sts` is 0.
- R2: Among enabled pending causes the highest wins, in this order: line error 6'b000110, receive timeout 6'b001100, receive threshold 6'b000100, transmit threshold 6'b000010, XOFF/special 6'b010000, modem pins 6'b100000. With none pending the code is 6'b000001.
- R3: `ier` bit 0 enables receive threshold and timeout, bit 1 transmit threshold, bit 2 line error, bit 3 modem pins and bit 4 XOFF/special. A pending cause whose bit is 0 shows neither in the code nor on `irq_n`, but stays pending and appears once its bit is set.
- R4: The line error flag is set by `ev_line_err` and is not cleared by an identification read. With `fifo_en`=1 a pulse on `lsr_rd` clears it. With `fifo_en`=0, `lsr_rd` clears it only after `rx_fifo_clr` has pulsed while the flag was set.
- R5: An XOFF flag set by `ev_xoff` is cleared only by `ev_xon`. Identification reads leave it pending.
- R6: A special-character flag set by `ev_special` is cleared by an identification read that returns 6'b010000. That read does not clear a pending XOFF flag.
- R7: A 0-to-1 transition on `cts_n`, `rts_n` or `dsr_n` sets the modem flag, and a 1-to-0 transition does not. The flag clears on a read that returns 6'b100000.
- R8: An `iir_rd` pulse loads `iir_rdata` with the code shown in that cycle, one cycle later. Only the cause named by that code is cleared, and a cause that arrives in the read cycle stays pending. The receive timeout flag clears on a read that returns 6'b001100.
- R9: With `fifo_en`=1 the receive threshold is `rx_trig4`*DEPTH/16 when `rx_trig4` is nonzero and (`rx_sel2`+1)*DEPTH/4 otherwise. The cause is pending while `rx_level` is at least the threshold.
- R10: With `fifo_en`=1 the transmit threshold is chosen the same way from `tx_trig4` and `tx_sel2`. The cause is pending while `tx_level` is at most the threshold.
- R11: With `fifo_en`=0 the receive cause is pending while `rx_level` is nonzero, and the transmit cause is pending while `tx_level` is zero.
- R12: `ev_wake` sets `wake_sts` only while `wake_en` is 1. `wake_sts` does not affect `iir_code`, survives identification reads, and is 0 in the cycle after `wake_en` is 0.
- R13: `irq_n` is 0 exactly when some enabled cause is pending or `wake_sts` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fifo_en | input | 1 | FIFO mode select |
| rx_fifo_clr | input | 1 | Receive FIFO clear strobe |
| ier | input | 5 | Per-cause interrupt enables |
| rx_level | input | LW | Receive FIFO fill level |
| tx_level | input | LW | Transmit FIFO fill level |
| rx_trig4 | input | 4 | Fine receive trigger field |
| rx_sel2 | input | 2 | Coarse receive trigger field |
| tx_trig4 | input | 4 | Fine transmit trigger field |
| tx_sel2 | input | 2 | Coarse transmit trigger field |
| ev_line_err | input | 1 | Receive line error event |
| lsr_rd | input | 1 | Line status register read strobe |
| ev_rx_tmo | input | 1 | Receive timeout event |
| ev_xoff | input | 1 | XOFF character detected |
| ev_special | input | 1 | Special character detected |
| ev_xon | input | 1 | XON character detected |
| cts_n | input | 1 | Clear-to-send pin, active low |
| rts_n | input | 1 | Request-to-send pin, active low |
| dsr_n | input | 1 | Data-set-ready pin, active low |
| wake_en | input | 1 | Wake-up enable |
| ev_wake | input | 1 | Wake-up event |
| iir_rd | input | 1 | Identification register read strobe |
| iir_code | output | 6 | Live identification code |
| iir_rdata | output | 6 | Code captured by the last read |
| irq_n | output | 1 | Interrupt request, active low |
| wake_sts | output | 1 | Wake-up status |

## Verification
The bench targets the clearing rules that differ by cause. It checks that an identification read leaves an XOFF pending while removing a special character that shares its code. A design that cleared by code instead of by cause would drop the XOFF too early. It holds a line error with the FIFO disabled against status reads until the clear strobe arrives, which catches a design that ignores the mode. It raises a new cause in the same cycle as a read and checks that the cause survives, which a design that cleared everything on a read would lose. Table vectors cover both threshold sources, both threshold edges, non-FIFO mode and masking. Directed cases confirm that a falling modem pin raises nothing and that wake-up status leaves the code untouched.

// File: rtl/uart_irq_prioritizer.sv
module uart_irq_prioritizer #(
  parameter int DEPTH = 64,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_en,
  input  logic          rx_fifo_clr,
  input  logic [4:0]    ier,
  input  logic [LW-1:0] rx_level,
  input  logic [LW-1:0] tx_level,
  input  logic [3:0]    rx_trig4,
  input  logic [1:0]    rx_sel2,
  input  logic [3:0]    tx_trig4,
  input  logic [1:0]    tx_sel2,
  input  logic          ev_line_err,
  input  logic          lsr_rd,
  input  logic          ev_rx_tmo,
  input  logic          ev_xoff,
  input  logic          ev_special,
  input  logic          ev_xon,
  input  logic          cts_n,
  input  logic          rts_n,
  input  logic          dsr_n,
  input  logic          wake_en,
  input  logic          ev_wake,
  input  logic          iir_rd,
  output logic [5:0]    iir_code,
  output logic [5:0]    iir_rdata,
  output logic          irq_n,
  output logic          wake_sts
);
  localparam int FINE   = DEPTH / 16;
  localparam int COARSE = DEPTH / 4;

  localparam logic [5:0] C_NONE = 6'b000001;
  localparam logic [5:0] C_LINE = 6'b000110;
  localparam logic [5:0] C_TMO  = 6'b001100;
  localparam logic [5:0] C_RX   = 6'b000100;
  localparam logic [5:0] C_TX   = 6'b000010;
  localparam logic [5:0] C_XS   = 6'b010000;
  localparam logic [5:0] C_MDM  = 6'b100000;

  function automatic int pick_thr(input logic [3:0] fine, input logic [1:0] coarse);
    if (fine != 4'd0) return int'(fine) * FINE;
    return (int'(coarse) + 1) * COARSE;
  endfunction

  logic       ls_flag, clr_armed, tmo_flag, xoff_flag, spec_flag, modem_flag;
  logic [2:0] pins_q;

  wire [2:0] pins_now = {cts_n, rts_n, dsr_n};
  wire       pin_rise = |(pins_now & ~pins_q);

  wire rx_hit = fifo_en ? (int'(rx_level) >= pick_thr(rx_trig4, rx_sel2)) : (rx_level != '0);
  wire tx_hit = fifo_en ? (int'(tx_level) <= pick_thr(tx_trig4, tx_sel2)) : (tx_level == '0);

  wire ls_p  = ls_flag & ier[2];
  wire tmo_p = tmo_flag & ier[0];
  wire rx_p  = rx_hit & ier[0];
  wire tx_p  = tx_hit & ier[1];
  wire xs_p  = (xoff_flag | spec_flag) & ier[4];
  wire md_p  = modem_flag & ier[3];

  always_comb begin
    if (ls_p)       iir_code = C_LINE;
    else if (tmo_p) iir_code = C_TMO;
    else if (rx_p)  iir_code = C_RX;
    else if (tx_p)  iir_code = C_TX;
    else if (xs_p)  iir_code = C_XS;
    else if (md_p)  iir_code = C_MDM;
    else            iir_code = C_NONE;
  end

  assign irq_n = ~(ls_p | tmo_p | rx_p | tx_p | xs_p | md_p | wake_sts);

  wire ls_clear  = lsr_rd & (fifo_en | clr_armed);
  wire rd_tmo    = iir_rd & (iir_code == C_TMO);
  wire rd_xs     = iir_rd & (iir_code == C_XS);
  wire rd_mdm    = iir_rd & (iir_code == C_MDM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ls_flag    <= 1'b0;
      clr_armed  <= 1'b0;
      tmo_flag   <= 1'b0;
      xoff_flag  <= 1'b0;
      spec_flag  <= 1'b0;
      modem_flag <= 1'b0;
      wake_sts   <= 1'b0;
      pins_q     <= 3'b111;
      iir_rdata  <= C_NONE;
    end else begin
      ls_flag    <= ev_line_err | (ls_flag & ~ls_clear);
      clr_armed  <= ls_flag & ~ls_clear & (clr_armed | rx_fifo_clr);
      tmo_flag   <= ev_rx_tmo | (tmo_flag & ~rd_tmo);
      xoff_flag  <= ev_xoff | (xoff_flag & ~ev_xon);
      spec_flag  <= ev_special | (spec_flag & ~rd_xs);
      modem_flag <= pin_rise | (modem_flag & ~rd_mdm);
      wake_sts   <= wake_en & (wake_sts | ev_wake);
      pins_q     <= pins_now;
      if (iir_rd) iir_rdata <= iir_code;
    end
  end
endmodule

// File: rtl/uart_irq_prioritizer_chk.sv
module uart_irq_prioritizer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [4:0] ier,
  input logic       fifo_en,
  input logic       ev_rx_tmo,
  input logic       ev_xon,
  input logic       iir_rd,
  input logic [5:0] iir_code,
  input logic       irq_n,
  input logic       wake_en,
  input logic       wake_sts,
  input logic       xoff_flag,
  input logic       ls_flag,
  input logic       clr_armed
);
  p_xoff_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (xoff_flag && !ev_xon) |=> xoff_flag);

  p_ls_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ls_flag && !fifo_en && !clr_armed) |=> ls_flag);

  p_tmo_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (iir_rd && iir_code == 6'b001100 && !ev_rx_tmo) |=> (iir_code != 6'b001100));

  p_wake_off_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !wake_en |=> !wake_sts);

  p_irq_code_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (iir_code != 6'b000001) |-> !irq_n);

  p_mask_all_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ier == 5'b0 && !wake_sts) |-> (irq_n && iir_code == 6'b000001));
endmodule

bind uart_irq_prioritizer uart_irq_prioritizer_chk u_chk (.*);

// File: tb/uart_irq_prioritizer_test.sv
`timescale 1ns/1ps
module uart_irq_prioritizer_test;
  logic clk = 0, rst_n = 0;
  logic fifo_en = 1, rx_fifo_clr = 0;
  logic [4:0] ier = 0;
  logic [6:0] rx_level = 0, tx_level = 64;
  logic [3:0] rx_trig4 = 0, tx_trig4 = 0;
  logic [1:0] rx_sel2 = 0, tx_sel2 = 0;
  logic ev_line_err = 0, lsr_rd = 0, ev_rx_tmo = 0, ev_xoff = 0, ev_special = 0, ev_xon = 0;
  logic cts_n = 1, rts_n = 1, dsr_n = 1, wake_en = 0, ev_wake = 0, iir_rd = 0;
  logic [5:0] iir_code, iir_rdata;
  logic irq_n, wake_sts;
  int errors = 0, checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  uart_irq_prioritizer uut (.*);

  typedef struct packed {
    logic fe; logic [4:0] ie; logic [6:0] rl; logic [6:0] tl;
    logic [3:0] tr; logic [1:0] fr; logic [3:0] tt; logic [1:0] ft; logic [5:0] code;
  } vec_t;

  localparam vec_t VT [12] = '{
    '{1'b1, 5'b00011, 7'd16, 7'd40, 4'd0, 2'd0, 4'd0,  2'd0, 6'b000100},
    '{1'b1, 5'b00011, 7'd15, 7'd40, 4'd0, 2'd0, 4'd0,  2'd0, 6'b000001},
    '{1'b1, 5'b00011, 7'd15, 7'd16, 4'd0, 2'd0, 4'd0,  2'd0, 6'b000010},
    '{1'b1, 5'b00011, 7'd20, 7'd40, 4'd5, 2'd0, 4'd0,  2'd0, 6'b000100},
    '{1'b1, 5'b00011, 7'd19, 7'd40, 4'd5, 2'd0, 4'd10, 2'd0, 6'b000010},
    '{1'b1, 5'b00011, 7'd47, 7'd49, 4'd0, 2'd2, 4'd0,  2'd2, 6'b000001},
    '{1'b1, 5'b00011, 7'd48, 7'd0,  4'd0, 2'd2, 4'd0,  2'd2, 6'b000100},
    '{1'b0, 5'b00011, 7'd1,  7'd5,  4'd0, 2'd0, 4'd0,  2'd0, 6'b000100},
    '{1'b0, 5'b00011, 7'd0,  7'd0,  4'd0, 2'd0, 4'd0,  2'd0, 6'b000010},
    '{1'b0, 5'b00011, 7'd0,  7'd1,  4'd0, 2'd0, 4'd0,  2'd0, 6'b000001},
    '{1'b1, 5'b00010, 7'd64, 7'd0,  4'd0, 2'd0, 4'd0,  2'd0, 6'b000010},
    '{1'b1, 5'b00000, 7'd64, 7'd0,  4'd0, 2'd0, 4'd0,  2'd0, 6'b000001}
  };

  task automatic chk(input string req, input logic [5:0] act, input logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic read_iir();
    iir_rd = 1; step(); iir_rd = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) step();
    chk("R1 code", iir_code, 6'b000001);
    chk("R1 rdata", iir_rdata, 6'b000001);
    chk("R1 irq_n", {5'b0, irq_n}, 6'd1);
    chk("R1 wake", {5'b0, wake_sts}, 6'd0);
    rst_n = 1; step();

    for (int i = 0; i < 12; i++) begin
      fifo_en = VT[i].fe; ier = VT[i].ie; rx_level = VT[i].rl; tx_level = VT[i].tl;
      rx_trig4 = VT[i].tr; rx_sel2 = VT[i].fr; tx_trig4 = VT[i].tt; tx_sel2 = VT[i].ft;
      #1;
      chk($sformatf("R9 R10 R11 vec%0d code", i), iir_code, VT[i].code);
      chk($sformatf("R13 vec%0d irq_n", i), {5'b0, irq_n}, {5'b0, VT[i].code == 6'b000001});
      step();
    end
    fifo_en = 1; rx_level = 0; tx_level = 64; rx_trig4 = 0; tx_trig4 = 0; rx_sel2 = 0; tx_sel2 = 0;

    ier = 5'b00100;
    ev_line_err = 1; step(); ev_line_err = 0;
    chk("R4 set", iir_code, 6'b000110);
    read_iir();
    chk("R4 survives iir read", iir_code, 6'b000110);
    lsr_rd = 1; step(); lsr_rd = 0;
    chk("R4 fifo mode lsr clear", iir_code, 6'b000001);
    fifo_en = 0;
    ev_line_err = 1; step(); ev_line_err = 0;
    lsr_rd = 1; step(); lsr_rd = 0;
    chk("R4 no clear without strobe", iir_code, 6'b000110);
    rx_fifo_clr = 1; step(); rx_fifo_clr = 0;
    lsr_rd = 1; step(); lsr_rd = 0;
    chk("R4 clear after strobe", iir_code, 6'b000001);
    fifo_en = 1; tx_level = 64;

    ier = 5'b11111;
    cts_n = 0; step(); cts_n = 1;
    ev_line_err = 1; ev_rx_tmo = 1; ev_xoff = 1; step();
    ev_line_err = 0; ev_rx_tmo = 0; ev_xoff = 0; step();
    chk("R2 line first", iir_code, 6'b000110);
    lsr_rd = 1; step(); lsr_rd = 0;
    chk("R2 timeout next", iir_code, 6'b001100);
    read_iir();
    chk("R8 rdata timeout", iir_rdata, 6'b001100);
    chk("R8 timeout cleared", iir_code, 6'b010000);
    read_iir();
    chk("R5 rdata xoff", iir_rdata, 6'b010000);
    chk("R5 xoff kept after read", iir_code, 6'b010000);
    ev_xon = 1; step(); ev_xon = 0;
    chk("R5 xon clears, modem shows", iir_code, 6'b100000);
    read_iir();
    chk("R7 modem cleared", iir_code, 6'b000001);
    chk("R13 idle irq_n", {5'b0, irq_n}, 6'd1);

    dsr_n = 0; step(); step();
    chk("R7 falling pin ignored", iir_code, 6'b000001);
    dsr_n = 1; step(); step();
    chk("R7 rising pin raises", iir_code, 6'b100000);
    read_iir();

    ev_special = 1; step(); ev_special = 0;
    chk("R6 special set", iir_code, 6'b010000);
    read_iir();
    chk("R6 special cleared", iir_code, 6'b000001);
    ev_special = 1; ev_xoff = 1; step(); ev_special = 0; ev_xoff = 0;
    read_iir();
    chk("R6 read keeps xoff", iir_code, 6'b010000);
    ev_xon = 1; step(); ev_xon = 0;
    chk("R6 R5 all cleared", iir_code, 6'b000001);

    ev_rx_tmo = 1; step(); ev_rx_tmo = 0;
    iir_rd = 1; ev_special = 1; step(); iir_rd = 0; ev_special = 0;
    chk("R8 returned code", iir_rdata, 6'b001100);
    chk("R8 late arrival kept", iir_code, 6'b010000);
    read_iir();

    ier = 5'b00000;
    ev_special = 1; step(); ev_special = 0;
    chk("R3 masked code", iir_code, 6'b000001);
    chk("R3 masked irq_n", {5'b0, irq_n}, 6'd1);
    ier = 5'b10000; #1;
    chk("R3 unmasked shows", iir_code, 6'b010000);
    step(); read_iir();
    ier = 5'b00000;

    ev_wake = 1; step(); ev_wake = 0;
    chk("R12 wake disabled", {5'b0, wake_sts}, 6'd0);
    wake_en = 1; ev_wake = 1; step(); ev_wake = 0;
    chk("R12 wake set", {5'b0, wake_sts}, 6'd1);
    chk("R13 wake drives irq", {5'b0, irq_n}, 6'd0);
    chk("R12 code untouched", iir_code, 6'b000001);
    read_iir();
    chk("R12 survives read", {5'b0, wake_sts}, 6'd1);
    wake_en = 0; step();
    chk("R12 cleared by enable", {5'b0, wake_sts}, 6'd0);
    chk("R13 irq released", {5'b0, irq_n}, 6'd1);

    finish_run();
  end
endmodule